// File: doc/BRIEF.md
# Hall-Sensor Three-Phase Commutation Controller

This block is the digital commutation core of a sensored three-phase brushless motor drive. It takes three Hall logic bits from off-block comparators and a run/stop level. It also takes a deceleration request from the speed loop, a braking-style select, a chopping level from an external duty comparator, a current-limit trip and a protection lock-off. From these it produces six gate enables, one high-side and one low-side per phase.

The Hall bits are synchronised and debounced. The accepted pattern selects one of six drive states. In each state one phase is driven high, one is driven low and one floats. The high-side switch of the active pair stays on for the whole state. Chopping is applied only to the low-side switch. When the speed loop asks for deceleration, the block either releases every switch so the motor coasts, or drives the state three steps away so that the motor receives braking torque.

A current-limit trip that persists past a blanking window cuts the low-side switch until the next rising edge of the chopping signal. This keeps short diode-recovery spikes from cutting the drive. A lock-off input from the protection logic forces every low-side switch off.

Top module: `bldc_hall_commutator`

## Requirements
- R1: Hall inputs are coded as hall_in[0]=H1, hall_in[1]=H2, hall_in[2]=H3, and gate bit 0 belongs to phase 1. While running with chopping high, the (H1,H2,H3) patterns map as follows, with the phase not named left off:
  - 101: phase 1 low, phase 2 high.
  - 100: phase 1 low, phase 3 high.
  - 110: phase 2 low, phase 3 high.
  - 010: phase 1 high, phase 2 low.
  - 011: phase 1 high, phase 3 low.
  - 001: phase 2 high, phase 3 low.
- R2: The patterns 000 and 111 switch all six gates off.
- R3: The high-side gate of the active pair does not depend on pwm_in. The low-side gate is on only while pwm_in is 1. No phase ever has both its gates on.
- R4: While run_n is 1, all six gates are off.
- R5: While decel_req is 1 and coast_sel is 1, all six gates are off.
- R6: While decel_req is 1 and coast_sel is 0, each pattern drives the state three steps away in the R1 order. This swaps the high and low roles of the two active phases, and the low side is still chopped by pwm_in.
- R7: An ilim_trip held for fewer than BLANK_CYCLES consecutive clocks has no effect. One held for BLANK_CYCLES consecutive clocks turns the low-side gate off from the next cycle, while the high-side gate stays on.
- R8: After a qualified trip, the low-side gate stays off, even with ilim_trip released, until the first clock that sees pwm_in at 1 after a clock that saw it at 0.
- R9: While lockoff is 1, all low-side gates are off and the high-side gates follow R1.
- R10: A Hall pattern change is applied only after the synchronised pattern has been steady for STABLE_CYCLES clocks. A change lasting fewer than STABLE_CYCLES clocks is ignored. The total delay from an input change to its use is STABLE_CYCLES+3 clocks.
- R11: After reset, all gates are off until a valid pattern has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | 3 | Hall logic bits, bit 0 = H1 |
| run_n | input | 1 | 0 runs the motor, 1 stops it |
| decel_req | input | 1 | Deceleration request from the speed loop |
| coast_sel | input | 1 | 1 coasts on deceleration, 0 brakes by reverse torque |
| pwm_in | input | 1 | Chopping level from the duty comparator |
| ilim_trip | input | 1 | Current-limit comparator output |
| lockoff | input | 1 | Protection lock-off, forces low sides off |
| gate_hi | output | 3 | High-side gate enables, bit 0 = phase 1 |
| gate_lo | output | 3 | Low-side gate enables, bit 0 = phase 1 |

## Verification
The bench builds the block with STABLE_CYCLES=4 and BLANK_CYCLES=4. This makes the debounce and blanking windows short enough that patterns just below and at each threshold can be driven in a few clocks. With these values, every one of the eight Hall patterns can be swept against forward, coast and reverse-torque operation with chopping both high and low. The trip-then-release sequence and the glitch rejection are then exercised at their exact clock boundaries.

// File: rtl/bldc_comm_pkg.sv
package bldc_comm_pkg;

    typedef enum logic [1:0] {
        DRV_OFF  = 2'd0,
        DRV_HIGH = 2'd1,
        DRV_LOW  = 2'd2
    } drv_e;

    typedef struct packed {
        drv_e p3;
        drv_e p2;
        drv_e p1;
    } pair_t;

    localparam int NPHASE = 3;
    localparam int NSTEP  = 6;

    // Returns {valid, step}; input bit 0 = H1.
    function automatic logic [3:0] hall_step(input logic [2:0] h);
        logic [3:0] r;
        case ({h[0], h[1], h[2]})
            3'b101:  r = {1'b1, 3'd0};
            3'b100:  r = {1'b1, 3'd1};
            3'b110:  r = {1'b1, 3'd2};
            3'b010:  r = {1'b1, 3'd3};
            3'b011:  r = {1'b1, 3'd4};
            3'b001:  r = {1'b1, 3'd5};
            default: r = {1'b0, 3'd0};
        endcase
        return r;
    endfunction

    function automatic logic [2:0] step_opposite(input logic [2:0] s);
        return (s >= 3'd3) ? s - 3'd3 : s + 3'd3;
    endfunction

    function automatic pair_t step_pair(input logic [2:0] s);
        pair_t d;
        case (s)
            3'd0:    d = '{p3: DRV_OFF,  p2: DRV_HIGH, p1: DRV_LOW };
            3'd1:    d = '{p3: DRV_HIGH, p2: DRV_OFF,  p1: DRV_LOW };
            3'd2:    d = '{p3: DRV_HIGH, p2: DRV_LOW,  p1: DRV_OFF };
            3'd3:    d = '{p3: DRV_OFF,  p2: DRV_LOW,  p1: DRV_HIGH};
            3'd4:    d = '{p3: DRV_LOW,  p2: DRV_OFF,  p1: DRV_HIGH};
            3'd5:    d = '{p3: DRV_LOW,  p2: DRV_HIGH, p1: DRV_OFF };
            default: d = '{p3: DRV_OFF,  p2: DRV_OFF,  p1: DRV_OFF };
        endcase
        return d;
    endfunction

endpackage

// File: rtl/hall_debounce.sv
module hall_debounce #(
    parameter int STABLE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_in,
    output logic [2:0] hall_q
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(STABLE_CYCLES - 1);

    logic [2:0]    meta_q, sync_q, cand_q, acc_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            cand_q <= '0;
            acc_q  <= '0;
            cnt_q  <= '0;
        end else begin
            meta_q <= hall_in;
            sync_q <= meta_q;
            if (sync_q != cand_q) begin
                cand_q <= sync_q;
                cnt_q  <= '0;
            end else if (cnt_q != CNT_TOP) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                acc_q <= cand_q;
            end
        end
    end

    assign hall_q = acc_q;

    // R10
    accept_after_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(acc_q) |-> ($past(cnt_q) == CNT_TOP));

endmodule

// File: rtl/trip_blanker.sv
module trip_blanker #(
    parameter int BLANK_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_in,
    input  logic trip_in,
    output logic hold_o
);
    localparam int CW = $clog2(BLANK_CYCLES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(BLANK_CYCLES);
    localparam logic [CW-1:0] CNT_ARM = CW'(BLANK_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          pwm_d, hold_q;
    logic          pwm_rise;

    assign pwm_rise = pwm_in && !pwm_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pwm_d  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            pwm_d <= pwm_in;
            if (!trip_in)
                cnt_q <= '0;
            else if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
            if (pwm_rise)
                hold_q <= 1'b0;
            else if (trip_in && cnt_q >= CNT_ARM)
                hold_q <= 1'b1;
        end
    end

    assign hold_o = hold_q;

    // R7
    set_needs_trip_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_q) |-> $past(trip_in));

    // R8
    release_on_pwm_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_q) |-> ($past(pwm_in) && !$past(pwm_in, 2)));

endmodule

// File: rtl/comm_decode.sv
module comm_decode
    import bldc_comm_pkg::*;
(
    input  logic [2:0] hall_q,
    input  logic       reverse,
    output pair_t      drv,
    output logic       valid
);
    logic [3:0] st;
    logic [2:0] idx;

    always_comb begin
        st    = hall_step(hall_q);
        valid = st[3];
        idx   = reverse ? step_opposite(st[2:0]) : st[2:0];
        drv   = valid ? step_pair(idx)
                      : '{p3: DRV_OFF, p2: DRV_OFF, p1: DRV_OFF};
    end

endmodule

// File: rtl/bldc_hall_commutator.sv
module bldc_hall_commutator
    import bldc_comm_pkg::*;
#(
    parameter int STABLE_CYCLES = 16,
    parameter int BLANK_CYCLES  = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_in,
    input  logic       run_n,
    input  logic       decel_req,
    input  logic       coast_sel,
    input  logic       pwm_in,
    input  logic       ilim_trip,
    input  logic       lockoff,
    output logic [2:0] gate_hi,
    output logic [2:0] gate_lo
);
    logic [2:0] hall_q;
    logic       trip_hold;
    logic       reverse, valid, enable;
    pair_t      drv;
    drv_e       ph_drv [NPHASE];

    hall_debounce #(.STABLE_CYCLES(STABLE_CYCLES)) u_deb (
        .clk    (clk),
        .rst    (rst),
        .hall_in(hall_in),
        .hall_q (hall_q)
    );

    trip_blanker #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
        .clk    (clk),
        .rst    (rst),
        .pwm_in (pwm_in),
        .trip_in(ilim_trip),
        .hold_o (trip_hold)
    );

    assign reverse = decel_req && !coast_sel;

    comm_decode u_dec (
        .hall_q (hall_q),
        .reverse(reverse),
        .drv    (drv),
        .valid  (valid)
    );

    assign enable = !run_n && valid && !(decel_req && coast_sel);

    always_comb begin
        ph_drv[0] = drv.p1;
        ph_drv[1] = drv.p2;
        ph_drv[2] = drv.p3;
    end

    for (genvar i = 0; i < NPHASE; i++) begin : g_phase
        assign gate_hi[i] = enable && (ph_drv[i] == DRV_HIGH);
        assign gate_lo[i] = enable && (ph_drv[i] == DRV_LOW) && pwm_in
                            && !trip_hold && !lockoff;
    end

    // R3
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_hi & gate_lo) == 3'b000);

    // R3
    single_side_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate_hi) && $onehot0(gate_lo));

    // R4
    stop_all_off_chk: assert property (@(posedge clk) disable iff (rst)
        run_n |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

    // R5
    coast_all_off_chk: assert property (@(posedge clk) disable iff (rst)
        (decel_req && coast_sel) |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

    // R9
    lockoff_low_off_chk: assert property (@(posedge clk) disable iff (rst)
        lockoff |-> (gate_lo == 3'b000));

endmodule

// File: tb/bldc_hall_commutator_test.sv
module bldc_hall_commutator_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hall_in = 3'b000;
    logic       run_n = 1'b1, decel_req = 1'b0, coast_sel = 1'b1;
    logic       pwm_in = 1'b0, ilim_trip = 1'b0, lockoff = 1'b0;
    logic [2:0] gate_hi, gate_lo;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bldc_hall_commutator #(.STABLE_CYCLES(4), .BLANK_CYCLES(4)) uut (
        .clk(clk), .rst(rst), .hall_in(hall_in), .run_n(run_n),
        .decel_req(decel_req), .coast_sel(coast_sel), .pwm_in(pwm_in),
        .ilim_trip(ilim_trip), .lockoff(lockoff),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    // v = {H1,H2,H3}; returns {lo, hi} for forward drive.
    function automatic logic [5:0] fwd_model(input logic [2:0] v);
        case (v)
            3'b101:  return {3'b001, 3'b010};
            3'b100:  return {3'b001, 3'b100};
            3'b110:  return {3'b010, 3'b100};
            3'b010:  return {3'b010, 3'b001};
            3'b011:  return {3'b100, 3'b001};
            3'b001:  return {3'b100, 3'b010};
            default: return 6'b0;
        endcase
    endfunction

    function automatic logic [2:0] to_port(input logic [2:0] v);
        return {v[0], v[1], v[2]};
    endfunction

    task automatic check(input string req, input logic [2:0] hi, input logic [2:0] lo,
                         input logic [2:0] ehi, input logic [2:0] elo);
        checks++;
        if (hi !== ehi || lo !== elo) begin
            fails++;
            $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", req, hi, lo, ehi, elo);
        end
    endtask

    task automatic set_hall(input logic [2:0] v);
        @(negedge clk);
        hall_in = to_port(v);
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [5:0] e;
        repeat (3) @(negedge clk);
        run_n   = 1'b0;
        hall_in = to_port(3'b101);
        pwm_in  = 1'b1;
        rst     = 1'b0;
        // R11: accepted pattern is still the reset value
        check("R11", gate_hi, gate_lo, 3'b000, 3'b000);

        // R1 R2 R3 R5 R6 sweep
        for (int v = 0; v < 8; v++) begin
            set_hall(3'(v));
            for (int m = 0; m < 3; m++) begin
                for (int p = 0; p < 2; p++) begin
                    decel_req = (m != 0);
                    coast_sel = (m == 1);
                    pwm_in    = p[0];
                    #1;
                    e = fwd_model(3'(v));
                    if (m == 0)
                        check((v == 0 || v == 7) ? "R2" : (p == 0 ? "R3" : "R1"),
                              gate_hi, gate_lo, e[2:0], p[0] ? e[5:3] : 3'b000);
                    else if (m == 1)
                        check("R5", gate_hi, gate_lo, 3'b000, 3'b000);
                    else
                        check("R6", gate_hi, gate_lo, e[5:3], p[0] ? e[2:0] : 3'b000);
                end
            end
        end
        decel_req = 1'b0;
        coast_sel = 1'b1;
        pwm_in    = 1'b1;

        // R4 stop
        set_hall(3'b100);
        run_n = 1'b1;
        #1;
        check("R4", gate_hi, gate_lo, 3'b000, 3'b000);
        run_n = 1'b0;

        // R9 lock-off for each valid pattern
        lockoff = 1'b1;
        for (int v = 1; v < 7; v++) begin
            set_hall(3'(v));
            e = fwd_model(3'(v));
            check("R9", gate_hi, gate_lo, e[2:0], 3'b000);
        end
        lockoff = 1'b0;

        // R7 short trip ignored, full trip cuts low side
        set_hall(3'b101);
        ilim_trip = 1'b1;
        repeat (3) @(negedge clk);
        ilim_trip = 1'b0;
        check("R7", gate_hi, gate_lo, 3'b010, 3'b001);
        repeat (2) @(negedge clk);
        ilim_trip = 1'b1;
        repeat (4) @(negedge clk);
        check("R7", gate_hi, gate_lo, 3'b010, 3'b000);
        ilim_trip = 1'b0;
        repeat (3) @(negedge clk);
        // R8 still held after trip release
        check("R8", gate_hi, gate_lo, 3'b010, 3'b000);
        pwm_in = 1'b0;
        @(negedge clk);
        pwm_in = 1'b1;
        #1;
        check("R8", gate_hi, gate_lo, 3'b010, 3'b000);
        @(negedge clk);
        check("R8", gate_hi, gate_lo, 3'b010, 3'b001);

        // R10 glitch rejection and delayed acceptance
        @(negedge clk);
        hall_in = to_port(3'b100);
        repeat (3) @(negedge clk);
        hall_in = to_port(3'b101);
        repeat (12) @(negedge clk);
        check("R10", gate_hi, gate_lo, 3'b010, 3'b001);
        hall_in = to_port(3'b110);
        repeat (6) @(negedge clk);
        check("R10", gate_hi, gate_lo, 3'b010, 3'b001);
        @(negedge clk);
        check("R10", gate_hi, gate_lo, 3'b100, 3'b010);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule